// File: doc/BRIEF.md
# Dual Interval Timer with Shared Interrupt

This peripheral holds two independent timer channels. Each has a reload register, a control word and a running counter. Software reaches them through a plain word-addressed write port and a combinational read port. A channel loads its reload value and then counts up or down on every clock. When it wraps past its last value it fires a one-cycle event pulse and sets a sticky status flag. It can then either reload and keep running, which gives a periodic tick, or stop.

Both channels drive one interrupt line. That line is a registered OR of each channel's status flag, gated by its interrupt enable. A handler therefore reads both control words to find which channel fired, and clears the flag by writing a 1 to it. Writing a 0 to the flag leaves it unchanged. The status flag is set by the wrap event itself, not by a level. Once it is cleared, nothing is pending until the next wrap.

Top module: `dual_timer_irq`

## Requirements
- R1: After reset every register reads zero, irq_o is low and event_o is all zero.
- R2: The word address is {channel, field}, where field 0 is control/status, 1 is reload and 2 is counter. Control reads return status in bit 8 and the written control bits in bits 7:0. The control bits are: bit0 mode (0 = interval), bit1 down, bit2 pulse enable, bit4 auto-reload, bit5 hold-load, bit6 interrupt enable, bit7 run.
- R3: With run set, hold-load clear and mode 0, the counter moves by one on each clock. It counts up when bit1 is 0 and down when bit1 is 1. The first step comes on the clock after the control write.
- R4: While hold-load is set, the counter is held at the reload value and does not count.
- R5: An up-counting channel wraps on the clock where its count is all ones. On that clock it sets status bit 8 and, if bit2 is set, drives its event_o bit high for exactly one cycle.
- R6: With auto-reload set, the channel loads its reload value at each wrap and keeps running. For an up count from reload L, events come every 2^32 - L cycles.
- R7: Without auto-reload, the counter takes the wrapped value (zero when counting up, all ones when counting down). The run bit clears and counting stops.
- R8: A down-counting channel wraps on the clock where its count is zero. Starting from reload L, the first event comes L + 1 cycles after the start.
- R9: Writing 1 to bit 8 of a control word clears that channel's status. Writing 0 to bit 8 leaves it unchanged.
- R10: irq_o is high one cycle after any channel has both status and interrupt enable set, and low one cycle after none has.
- R11: A channel whose interrupt enable is clear still sets its status but does not raise irq_o.
- R12: With mode bit0 set, the counter does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address {channel, field} |
| wr_en_i | input | 1 | Write strobe, taken on the clock edge |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Combinational read data for addr_i |
| irq_o | output | 1 | Registered combined interrupt |
| event_o | output | NUM_TIMERS | One-cycle wrap pulse per channel |

## Verification
A control write takes effect on the edge that samples it. The first count step follows one edge later. A channel started from reload L therefore wraps, raises event_o and sets its status at start edge plus 2^32 - L when counting up, or plus L + 1 when counting down. irq_o follows one edge after that. The driver records the start edge and queues each expected event cycle. The monitor checks every event_o pulse against that queue, so any pulse that is early, late, extra or missing is reported. Register and irq_o reads are taken on falling edges at exactly those offsets.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int CTL_W  = 9;
  localparam int B_MODE = 0;
  localparam int B_DOWN = 1;
  localparam int B_GEN  = 2;
  localparam int B_ARLD = 4;
  localparam int B_LOAD = 5;
  localparam int B_IE   = 6;
  localparam int B_EN   = 7;
  localparam int B_STS  = 8;

  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_LOAD = 2'd1,
    FLD_CNT  = 2'd2
  } fld_e;
endpackage

// File: rtl/dtmr_unit.sv
module dtmr_unit
  import dtmr_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctrl_i,
  input  logic             wr_load_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [CTL_W-1:0] ctrl_o,
  output logic [WIDTH-1:0] load_o,
  output logic [WIDTH-1:0] cnt_o,
  output logic             evt_o,
  output logic             irq_req_o
);
  logic [7:0]       cfg_q;
  logic             sts_q;
  logic             evt_q;
  logic [WIDTH-1:0] load_q, cnt_q, cnt_d;
  logic             run, at_end, wrap;

  assign run    = cfg_q[B_EN] & ~cfg_q[B_LOAD] & ~cfg_q[B_MODE];
  assign at_end = cfg_q[B_DOWN] ? (cnt_q == '0) : (cnt_q == '1);
  assign wrap   = run & at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (cfg_q[B_LOAD]) begin
      cnt_d = load_q;
    end else if (run) begin
      if (wrap)
        cnt_d = cfg_q[B_ARLD] ? load_q : (cfg_q[B_DOWN] ? '1 : '0);
      else
        cnt_d = cfg_q[B_DOWN] ? cnt_q - WIDTH'(1) : cnt_q + WIDTH'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      sts_q  <= 1'b0;
      evt_q  <= 1'b0;
      load_q <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      evt_q <= wrap & cfg_q[B_GEN];
      if (wr_load_i) load_q <= wdata_i;
      if (wr_ctrl_i) cfg_q <= wdata_i[7:0];
      else if (wrap && !cfg_q[B_ARLD]) cfg_q[B_EN] <= 1'b0;
      // set wins over a same-cycle clear
      if (wrap) sts_q <= 1'b1;
      else if (wr_ctrl_i && wdata_i[B_STS]) sts_q <= 1'b0;
    end
  end

  assign ctrl_o    = {sts_q, cfg_q};
  assign load_o    = load_q;
  assign cnt_o     = cnt_q;
  assign evt_o     = evt_q;
  assign irq_req_o = sts_q & cfg_q[B_IE];

  // R9
  sts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_q && !(wr_ctrl_i && wdata_i[B_STS]) |=> sts_q);
  // R5
  evt_sts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> sts_q);
  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q[B_LOAD] && !wr_ctrl_i && !wr_load_i |=> cnt_q == load_q);
  // R7
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && at_end && !cfg_q[B_ARLD] && !wr_ctrl_i |=> !cfg_q[B_EN]);
  // R8
  down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && !at_end && cfg_q[B_DOWN] |=> cnt_q == $past(cnt_q) - WIDTH'(1));
endmodule

// File: rtl/dtmr_irq_merge.sv
module dtmr_irq_merge #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |req_i;
  end

  assign irq_o = irq_q;

  // R10
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> irq_o);
  // R10
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_i) |=> !irq_o);
endmodule

// File: rtl/dual_timer_irq.sv
module dual_timer_irq
  import dtmr_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int NUM_TIMERS = 2,
  parameter int ADDR_W     = $clog2(NUM_TIMERS) + 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_en_i,
  input  logic [WIDTH-1:0]      wdata_i,
  output logic [WIDTH-1:0]      rdata_o,
  output logic                  irq_o,
  output logic [NUM_TIMERS-1:0] event_o
);
  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0]      sel;
  logic [1:0]            fld;
  logic [CTL_W-1:0]      ctrl_a [NUM_TIMERS];
  logic [WIDTH-1:0]      load_a [NUM_TIMERS];
  logic [WIDTH-1:0]      cnt_a  [NUM_TIMERS];
  logic [NUM_TIMERS-1:0] req;

  assign sel = addr_i[ADDR_W-1:2];
  assign fld = addr_i[1:0];

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_unit
    logic hit;
    assign hit = wr_en_i && (sel == SEL_W'(g));
    dtmr_unit #(.WIDTH(WIDTH)) u_unit (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_ctrl_i (hit && fld == FLD_CTRL),
      .wr_load_i (hit && fld == FLD_LOAD),
      .wdata_i   (wdata_i),
      .ctrl_o    (ctrl_a[g]),
      .load_o    (load_a[g]),
      .cnt_o     (cnt_a[g]),
      .evt_o     (event_o[g]),
      .irq_req_o (req[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (sel == SEL_W'(i)) begin
        case (fld)
          FLD_CTRL: rdata_o = WIDTH'(ctrl_a[i]);
          FLD_LOAD: rdata_o = load_a[i];
          FLD_CNT:  rdata_o = cnt_a[i];
          default:  rdata_o = '0;
        endcase
      end
    end
  end

  dtmr_irq_merge #(.N(NUM_TIMERS)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .irq_o  (irq_o)
  );
endmodule

// File: tb/sim_dual_timer_irq.sv
module sim_dual_timer_irq;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   addr = '0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         irq;
  logic [1:0]   evt;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int q0[$];
  int q1[$];
  logic mon_on = 1'b0;

  dual_timer_irq u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .event_o(evt)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [W-1:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected event cycles per channel
  always @(negedge clk) begin
    if (mon_on) begin
      if (evt[0]) begin
        if (q0.size() == 0) chk("R5 ch0 unexpected event", 32'(cyc), 32'hFFFF_FFFF);
        else chk("R5/R6 ch0 event cycle", 32'(cyc), 32'(q0.pop_front()));
      end
      if (evt[1]) begin
        if (q1.size() == 0) chk("R8 ch1 unexpected event", 32'(cyc), 32'hFFFF_FFFF);
        else chk("R8 ch1 event cycle", 32'(cyc), 32'(q1.pop_front()));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p;
    idle(2);
    // R1 reset state
    for (int a = 0; a < 7; a++) if (a != 3) rd_chk("R1 reset reg", 3'(a), '0);
    chk("R1 reset irq", 32'(irq), 0);
    chk("R1 reset event", 32'(evt), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R4 hold at reload, R2 control readback
    wr(3'd1, 32'hFFFF_FFFC);
    wr(3'd0, 32'h0F4);
    idle(3);
    rd_chk("R4 held count", 3'd2, 32'hFFFF_FFFC);
    rd_chk("R2 ctrl readback", 3'd0, 32'h0F4);

    // R3 up count, R5 wrap, R6 periodic reload, R10 irq
    wr(3'd0, 32'h0D4);
    p = cyc;
    q0.push_back(p + 4); q0.push_back(p + 8); q0.push_back(p + 12);
    idle(1);
    rd_chk("R3 first step", 3'd2, 32'hFFFF_FFFD);
    idle(4);
    chk("R10 irq after wrap", 32'(irq), 1);
    rd_chk("R5 status set", 3'd0, 32'h1D4);
    idle(8);
    wr(3'd0, 32'h054);
    rd_chk("R9 write 0 keeps status", 3'd0, 32'h154);
    chk("R10 irq held", 32'(irq), 1);
    wr(3'd0, 32'h154);
    idle(1);
    rd_chk("R9 write 1 clears", 3'd0, 32'h054);
    chk("R10 irq drops", 32'(irq), 0);

    // R8 down count, R7 stop without reload, R10 OR via channel 1
    wr(3'd5, 32'd3);
    wr(3'd4, 32'h0E6);
    wr(3'd4, 32'h0C6);
    p = cyc;
    q1.push_back(p + 4);
    idle(1);
    rd_chk("R8 down step", 3'd6, 32'd2);
    idle(5);
    rd_chk("R7 down wraps to ones", 3'd6, 32'hFFFF_FFFF);
    rd_chk("R7 run cleared", 3'd4, 32'h146);
    chk("R10 irq from ch1", 32'(irq), 1);
    wr(3'd4, 32'h100);
    idle(1);
    chk("R9 ch1 clear drops irq", 32'(irq), 0);

    // R11 masked interrupt, R7 up stop at zero
    wr(3'd1, 32'hFFFF_FFFE);
    wr(3'd0, 32'h0A4);
    wr(3'd0, 32'h084);
    p = cyc;
    q0.push_back(p + 2);
    idle(4);
    rd_chk("R7 up wraps to zero", 3'd2, 32'd0);
    rd_chk("R11 status without enable", 3'd0, 32'h104);
    chk("R11 irq stays low", 32'(irq), 0);
    idle(3);
    rd_chk("R7 stays stopped", 3'd2, 32'd0);

    // R12 mode bit blocks counting
    wr(3'd4, 32'h081);
    idle(5);
    rd_chk("R12 no count in mode 1", 3'd6, 32'hFFFF_FFFF);

    idle(2);
    chk("R5 ch0 events all seen", 32'(q0.size()), 0);
    chk("R8 ch1 events all seen", 32'(q1.size()), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule